// File: doc/BRIEF.md
# Reset-Aligned Binary Pulse Divider

This block divides an external trigger clock by every power of two from 2 up to 2^STAGES. The default of eight stages gives the ratios /2 through /256. The trigger arrives without any timing relation to the system clock. A short synchronizer brings it into the system clock domain. Each divided output is a pulse. It is high for the whole synchronized high phase of the selected trigger periods and low at all other times.

Every trigger high phase gets an index counted from reset: the first high phase after reset is pulse 0. At each rising edge the index of the new pulse is captured and the index counter advances. The output for ratio 2^(i+1) passes the high phase only when the low i+1 bits of the captured index are all zero. Each output tests the inverted index bits in a ripple chain that runs from bit 0 upwards. As a result every ratio fires together on pulse 0, the first pulse after reset, and after that only on exact multiples of its ratio.

A two-state machine drives the sequence. IDLE waits while the synchronized trigger is low. BURST covers one synchronized high phase. The ARM transition (IDLE to BURST) fires when the synchronized trigger is high. It captures the current pulse index and advances the counter. The DROP transition (BURST to IDLE) fires when the synchronized trigger is low. Reset forces IDLE and clears the index counter.

Top module: `divpulse_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after a clock edge where it was high, `div_out` is all zero. The first trigger high phase after reset is pulse index 0.
- R2: Take pulse index k, counted from 0 after reset. Bit i of `div_out` is high during that pulse exactly when k mod 2^(i+1) equals 0. Bit 0 is the /2 output and bit STAGES-1 is the /2^STAGES output.
- R3: `div_out` is all zero whenever the synchronized trigger was low on the previous system clock edge, so nothing appears between pulses.
- R4: A rising trigger edge reaches `div_out` on the third rising `clk` edge after it, with the default SYNC_DEPTH of 2. A falling edge clears `div_out` after the same delay.
- R5: The index counter wraps modulo 2^STAGES. With the default of 8 stages, pulse 256 fires every output again, just like pulse 0.
- R6: Asserting `rst` in the middle of a sequence realigns every ratio. The next trigger pulse is index 0 and fires all outputs.
- R7: Within one high phase, `div_out` holds a constant value for any high width, so each trigger pulse produces at most one pulse on each output.
- R8: The outputs nest. Whenever bit i of `div_out` is high, every bit below i is also high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Asynchronous trigger clock to be divided |
| div_out | output | STAGES | Divided pulse outputs; bit i is the /2^(i+1) output |

## Verification
The bench builds the block with its default values, 8 stages and a two-flop synchronizer. It sweeps 300 consecutive trigger pulses, which covers every pulse index from 0 to 255, the wrap back to index 0 at pulse 256, and a few pulses beyond it. High and low widths vary from pulse to pulse. The bench checks each output against an index computed arithmetically, and checks the three-cycle latency on every edge. Resets placed at several points in a sequence check that all ratios realign.

// File: rtl/divpulse_pkg.sv
package divpulse_pkg;

    typedef enum logic [0:0] {
        PH_IDLE  = 1'b0,
        PH_BURST = 1'b1
    } phase_t;

endpackage

// File: rtl/divp_sync.sv
module divp_sync #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level_out
);
    logic [SYNC_DEPTH-1:0] chain;

    generate
        for (genvar g = 0; g < SYNC_DEPTH; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[g] <= 1'b0;
                end else begin
                    if (g == 0) chain[g] <= async_in;
                    else        chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign level_out = chain[SYNC_DEPTH-1];
endmodule

// File: rtl/divp_seq.sv
module divp_seq
    import divpulse_pkg::*;
#(
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              level,
    output phase_t            phase,
    output logic [STAGES-1:0] held_idx
);
    phase_t            phase_q, phase_d;
    logic [STAGES-1:0] next_idx;
    logic              arm;

    // state register
    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end

    // transitions: ARM and DROP
    always_comb begin
        phase_d = phase_q;
        arm     = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (level) begin
                    phase_d = PH_BURST;
                    arm     = 1'b1;
                end
            end
            PH_BURST: begin
                if (!level) phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // index capture and advance on ARM
    always_ff @(posedge clk) begin
        if (rst) begin
            next_idx <= '0;
            held_idx <= '0;
        end else if (arm) begin
            held_idx <= next_idx;
            next_idx <= next_idx + 1'b1;
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/divp_gate.sv
module divp_gate
    import divpulse_pkg::*;
#(
    parameter int STAGES = 8
) (
    input  phase_t            phase,
    input  logic [STAGES-1:0] held_idx,
    output logic [STAGES-1:0] pulses
);
    logic [STAGES-1:0] zero_run;
    logic              window;

    assign window = (phase == PH_BURST);

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_ripple
            if (g == 0) begin : g_first
                assign zero_run[g] = ~held_idx[g];
            end else begin : g_next
                assign zero_run[g] = zero_run[g-1] & ~held_idx[g];
            end
            assign pulses[g] = zero_run[g] & window;
        end
    endgenerate
endmodule

// File: rtl/divpulse_top.sv
module divpulse_top
    import divpulse_pkg::*;
#(
    parameter int STAGES     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_in,
    output logic [STAGES-1:0] div_out
);
    logic              trig_lvl;
    phase_t            phase;
    logic [STAGES-1:0] held_idx;

    divp_sync #(.SYNC_DEPTH(SYNC_DEPTH)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .async_in  (trig_in),
        .level_out (trig_lvl)
    );

    divp_seq #(.STAGES(STAGES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .level    (trig_lvl),
        .phase    (phase),
        .held_idx (held_idx)
    );

    divp_gate #(.STAGES(STAGES)) u_gate (
        .phase    (phase),
        .held_idx (held_idx),
        .pulses   (div_out)
    );
endmodule

// File: rtl/divpulse_chk.sv
module divpulse_chk #(
    parameter int STAGES = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              lvl,
    input logic [STAGES-1:0] outs
);
    // R1: reset leaves outputs quiet
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (outs == '0));

    // R3: no output unless the synchronized trigger was high
    a_r3_quiet_when_low: assert property (@(posedge clk) disable iff (rst)
        !lvl |=> (outs == '0));

    // R7: one constant value across a high phase
    a_r7_stable_in_burst: assert property (@(posedge clk) disable iff (rst)
        (lvl && $past(lvl) && (outs != '0)) |=> $stable(outs));

    // R2: the longest ratio firing implies all ratios firing
    a_r2_top_fires_all: assert property (@(posedge clk) disable iff (rst)
        outs[STAGES-1] |-> (outs == '1));

    // R8: nesting of ratios
    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_nest
            a_r8_nested: assert property (@(posedge clk) disable iff (rst)
                outs[g] |-> outs[g-1]);
        end
    endgenerate
endmodule

bind divpulse_top divpulse_chk #(.STAGES(STAGES)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .lvl  (trig_lvl),
    .outs (div_out)
);

// File: tb/divpulse_top_test.sv
module divpulse_top_test;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         trig_in = 1'b0;
    logic [N-1:0] div_out;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    divpulse_top #(.STAGES(N), .SYNC_DEPTH(2)) uut (
        .clk     (clk),
        .rst     (rst),
        .trig_in (trig_in),
        .div_out (div_out)
    );

    always #5 clk = ~clk;

    function automatic logic [N-1:0] expect_for(int k);
        logic [N-1:0] e;
        for (int i = 0; i < N; i++) e[i] = ((k % (1 << (i + 1))) == 0);
        return e;
    endfunction

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        trig_in = 1'b0;
        @(negedge clk);
        check("R1", div_out, '0);
        @(negedge clk);
        check("R1", div_out, '0);
        rst = 1'b0;
    endtask

    // one trigger pulse with index k (R2, R3, R4, R5, R7)
    task automatic pulse(int k, int hi, int lo);
        logic [N-1:0] e;
        e = expect_for(k);
        @(negedge clk);
        trig_in = 1'b1;
        @(negedge clk); check("R4", div_out, '0);
        @(negedge clk); check("R4", div_out, '0);
        @(negedge clk); check((k % (1 << N) == 0) ? "R5" : "R2", div_out, e);
        for (int c = 3; c < hi; c++) begin
            @(negedge clk); check("R7", div_out, e);
        end
        trig_in = 1'b0;
        @(negedge clk); check("R4", div_out, e);
        @(negedge clk); check("R4", div_out, e);
        for (int c = 2; c < lo; c++) begin
            @(negedge clk); check("R3", div_out, '0);
        end
    endtask

    initial begin
        do_reset();
        // R1 first pulse after reset fires all
        // full sweep including wrap (R5)
        for (int k = 0; k < 300; k++) pulse(k, 4 + (k % 4), 4 + (k % 3));
        // R6 reset mid-sequence at several points
        for (int r = 1; r < 6; r++) begin
            do_reset();
            for (int k = 0; k < 3 * r + 2; k++) pulse(k, 5, 5);
        end
        do_reset();
        pulse(0, 8, 6); // R6 realignment right after reset
        pulse(1, 3, 3);
        pulse(2, 3, 3);
        done = 1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: got hung expected done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule